// File: doc/BRIEF.md
# SD Command Issue Sequencer

This block is the command-issue front end of an SD/MMC host controller. Software writes a 32-bit command word. Setting the top bit of that word launches the command. The block decodes the opcode and the control flags and offers them to a simple command-line transmitter through a request/acknowledge handshake. After the transmitter reports the end bit, the block waits for a response or declares a response timeout. It then raises completion events for the interrupt unit.

The launch bit stays readable as 1 while a command is pending, so software can poll it. The launch bit clears itself at the moment the transmitter takes the command. Two launch flags change the flow. One holds the launch until the previous data transfer has finished. The other turns the write into a card-clock reprogram that sends nothing to the card. A third flag precedes the command with an initialization burst on the command line, which is held high for this burst. All timing inside the command is counted in card-clock ticks, which arrive as a one-cycle enable strobe.

Top module: `sd_cmd_issue`

## Requirements
- R1: While `tx_req` is high, `tx_opcode` equals bits [5:0] of the launched command word.
- R2: A write with bit 31 set makes `cmd_word[31]` read 1 from the next cycle on. `tx_req` stays high until a cycle with `tx_ack`. The cycle after that acknowledge, `cmd_word[31]` and `tx_req` are both 0.
- R3: A launched word with bit 21 set copies `clk_cfg_in` to `clk_cfg` and clears bit 31. It raises no `tx_req`, no `init_hold` and no `done_evt`. `clk_cfg` changes at no other time.
- R4: With bit 13 set, neither `tx_req` nor a clock update happens while `data_busy` is high. With bit 13 clear, `data_busy` does not delay the launch.
- R5: While `tx_req` is high, each flag output follows its bit of the command word: `tx_rsp` bit 6, `tx_long` bit 7, `tx_crc` bit 8, `tx_data` bit 9, `tx_write` bit 10, `tx_autostop` bit 12 and `tx_abort` bit 14.
- R6: With bit 15 set, `init_hold` is high for exactly 80 card-clock ticks before `tx_req` rises. With bit 15 clear, `init_hold` stays low.
- R7: With bit 6 clear, `done_evt` pulses for one cycle, two cycles after the `tx_end` cycle. With bit 6 set, a `rsp_done` in time gives `done_evt` two cycles later and no `timeout_evt`. A timeout pulses `timeout_evt`, and `done_evt` follows in the next cycle.
- R8: A response timeout fires after N card-clock ticks counted from the cycle after `tx_end`. N is `rsp_to`, or 64 when `rsp_to` is 0.
- R9: A write while `cmd_word[31]` reads 1 is ignored: the readback and the pending command are unchanged.
- R10: After reset, `cmd_word`, `clk_cfg`, `tx_req`, `init_hold`, `done_evt` and `timeout_evt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 32 | Command word written |
| cmd_word | output | 32 | Command register readback, bit 31 is the live launch flag |
| clk_cfg_in | input | 2 | Pending card-clock enable and low-power settings |
| clk_cfg | output | 2 | Applied card-clock settings |
| rsp_to | input | TO_W | Response timeout in card-clock ticks, 0 selects the default |
| data_busy | input | 1 | Previous data transfer still running |
| cclk_en | input | 1 | One-cycle strobe per card-clock cycle |
| init_hold | output | 1 | Initialization burst in progress, command line held high |
| tx_req | output | 1 | Command offered to the transmitter |
| tx_ack | input | 1 | Transmitter takes the command |
| tx_opcode | output | 6 | Command opcode |
| tx_rsp | output | 1 | Response expected |
| tx_long | output | 1 | 136-bit response instead of 48-bit |
| tx_crc | output | 1 | Check response CRC |
| tx_data | output | 1 | Command has a data phase |
| tx_write | output | 1 | Data direction is write |
| tx_autostop | output | 1 | Send a stop command after the data |
| tx_abort | output | 1 | Command is a stop or abort |
| tx_end | input | 1 | Transmitter has sent the end bit |
| rsp_done | input | 1 | Response received |
| done_evt | output | 1 | Command-done event pulse |
| timeout_evt | output | 1 | Response-timeout event pulse |

## Verification
Random command words vary the opcode and the flags together. This separates each flag output from its neighbours and shows that nothing leaks from one field into another. The random runs also mix plain commands, commands with the initialization burst and clock-update writes. These three split the path that reaches the transmitter from the one that only reprograms the clock. The response side runs three ways: no response, a response before the limit, and a silent card with either the default or a short programmed limit. Separating these shows that the timeout count is exact and that the completion event follows a timeout. Directed cases hold the data-busy input with and without the wait flag, and they write into a pending command to show that the write is dropped.

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue #(
  parameter int TO_W     = 16,
  parameter int DEF_TO   = 64,
  parameter int INIT_LEN = 80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     cmd_word,
  input  logic [1:0]      clk_cfg_in,
  output logic [1:0]      clk_cfg,
  input  logic [TO_W-1:0] rsp_to,
  input  logic            data_busy,
  input  logic            cclk_en,
  output logic            init_hold,
  output logic            tx_req,
  input  logic            tx_ack,
  output logic [5:0]      tx_opcode,
  output logic            tx_rsp,
  output logic            tx_long,
  output logic            tx_crc,
  output logic            tx_data,
  output logic            tx_write,
  output logic            tx_autostop,
  output logic            tx_abort,
  input  logic            tx_end,
  input  logic            rsp_done,
  output logic            done_evt,
  output logic            timeout_evt
);
  localparam int IW = $clog2(INIT_LEN + 1);
  localparam int CW = (TO_W > IW) ? TO_W : IW;

  typedef enum logic [2:0] {IDLE, LAUNCH, INIT, REQ, SEND, RESP, FIN} st_t;

  st_t          st;
  logic [30:0]  word_q;
  logic         start_q;
  logic         rsp_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = (rsp_to == '0) ? CW'(DEF_TO) : CW'(rsp_to);

  wire accept = wr_en && !start_q;
  wire to_hit = (st == RESP) && !rsp_done && cclk_en && (cnt == lim - CW'(1));
  wire go     = !(word_q[13] && data_busy);

  assign cmd_word    = {start_q, word_q};
  assign tx_req      = (st == REQ);
  assign init_hold   = (st == INIT);
  assign tx_opcode   = word_q[5:0];
  assign tx_rsp      = word_q[6];
  assign tx_long     = word_q[7];
  assign tx_crc      = word_q[8];
  assign tx_data     = word_q[9];
  assign tx_write    = word_q[10];
  assign tx_autostop = word_q[12];
  assign tx_abort    = word_q[14];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      word_q      <= '0;
      start_q     <= 1'b0;
      rsp_q       <= 1'b0;
      cnt         <= '0;
      clk_cfg     <= '0;
      done_evt    <= 1'b0;
      timeout_evt <= 1'b0;
    end else begin
      done_evt    <= (st == FIN);
      timeout_evt <= to_hit;
      if (accept) begin
        word_q  <= wr_data[30:0];
        start_q <= wr_data[31];
      end
      case (st)
        IDLE:   if (start_q) st <= LAUNCH;
        LAUNCH: if (go) begin
          if (word_q[21]) begin
            clk_cfg <= clk_cfg_in;
            start_q <= 1'b0;
            st      <= IDLE;
          end else if (word_q[15]) begin
            cnt <= '0;
            st  <= INIT;
          end else begin
            st <= REQ;
          end
        end
        INIT: if (cclk_en) begin
          if (cnt == CW'(INIT_LEN - 1)) begin
            cnt <= '0;
            st  <= REQ;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        REQ: if (tx_ack) begin
          start_q <= 1'b0;
          rsp_q   <= word_q[6];
          st      <= SEND;
        end
        SEND: if (tx_end) begin
          cnt <= '0;
          st  <= rsp_q ? RESP : FIN;
        end
        RESP: begin
          if (rsp_done || to_hit) st <= FIN;
          else if (cclk_en) cnt <= cnt + CW'(1);
        end
        FIN:     st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module sd_cmd_issue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] cmd_word,
  input logic [1:0]  clk_cfg,
  input logic        init_hold,
  input logic        tx_req,
  input logic        tx_ack,
  input logic        done_evt,
  input logic        timeout_evt
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_ack |=> tx_req);
  // R2
  req_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> cmd_word[31]);
  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cmd_word[31] |=> cmd_word[30:0] == $past(cmd_word[30:0]));
  // R7
  to_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> done_evt);
  // R3
  cfg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_cfg) |-> $fell(cmd_word[31]));
  // R6
  burst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_hold |-> !tx_req && cmd_word[31]);
endmodule

bind sd_cmd_issue sd_cmd_issue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_word(cmd_word),
  .clk_cfg(clk_cfg), .init_hold(init_hold), .tx_req(tx_req),
  .tx_ack(tx_ack), .done_evt(done_evt), .timeout_evt(timeout_evt)
);

// File: tb/sd_cmd_issue_test.sv
module sd_cmd_issue_test;
  localparam int TO_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] cmd_word;
  logic [1:0] clk_cfg_in = '0, clk_cfg;
  logic [TO_W-1:0] rsp_to = '0;
  logic data_busy = 1'b0, cclk_en = 1'b0;
  logic init_hold, tx_req, tx_ack = 1'b0;
  logic [5:0] tx_opcode;
  logic tx_rsp, tx_long, tx_crc, tx_data, tx_write, tx_autostop, tx_abort;
  logic tx_end = 1'b0, rsp_done = 1'b0;
  logic done_evt, timeout_evt;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sd_cmd_issue #(.TO_W(TO_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_word(cmd_word), .clk_cfg_in(clk_cfg_in), .clk_cfg(clk_cfg),
    .rsp_to(rsp_to), .data_busy(data_busy), .cclk_en(cclk_en),
    .init_hold(init_hold), .tx_req(tx_req), .tx_ack(tx_ack),
    .tx_opcode(tx_opcode), .tx_rsp(tx_rsp), .tx_long(tx_long), .tx_crc(tx_crc),
    .tx_data(tx_data), .tx_write(tx_write), .tx_autostop(tx_autostop),
    .tx_abort(tx_abort), .tx_end(tx_end), .rsp_done(rsp_done),
    .done_evt(done_evt), .timeout_evt(timeout_evt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    cclk_en = ~cclk_en;
  endtask

  function automatic logic [7:0] exp_flags(input logic [31:0] w);
    return {w[6], w[7], w[8], w[9], w[10], w[12], w[14], 1'b0};
  endfunction

  function automatic int exp_lim(input logic [TO_W-1:0] t);
    return (t == 0) ? 64 : int'(t);
  endfunction

  // rmode: 0 respond after rdly steps, 1 silent card
  task automatic run_cmd(input logic [31:0] w, input int busy, input int rmode,
                         input int rdly, input logic [TO_W-1:0] to,
                         input bit intr, input logic [31:0] iw);
    int bl = busy;
    int inits = 0;
    int guard = 0;
    int tk = 0;
    logic [7:0] fl;
    rsp_to = to;
    clk_cfg_in = 2'($urandom);
    data_busy = (busy > 0);
    wr_en = 1'b1; wr_data = w;
    step();
    wr_en = 1'b0;
    // R2 readback
    chk(cmd_word === w, "R2 launch readback", cmd_word, w);
    if (intr) begin
      wr_en = 1'b1; wr_data = iw;
      step();
      wr_en = 1'b0;
      // R9 write while pending
      chk(cmd_word === w, "R9 ignored write", cmd_word, w);
    end
    forever begin
      if (w[13] && data_busy && (tx_req || !cmd_word[31]))
        chk(1'b0, "R4 launch while busy", {31'b0, tx_req}, 32'h0);
      if (tx_req || !cmd_word[31]) break;
      if (init_hold && cclk_en) inits++;
      if (bl > 0) begin
        bl--;
        if (bl == 0) data_busy = 1'b0;
      end
      step();
      guard++;
      if (guard > 2000) begin
        chk(1'b0, "R2 no hand-off", cmd_word, w);
        return;
      end
    end
    if (w[21]) begin
      // R3 clock update
      chk(clk_cfg === clk_cfg_in, "R3 clock settings", {30'b0, clk_cfg}, {30'b0, clk_cfg_in});
      chk(!tx_req && inits == 0, "R3 no command", {31'b0, tx_req}, 32'h0);
      data_busy = 1'b0;
      for (int i = 0; i < 4; i++) begin
        step();
        if (done_evt || tx_req) chk(1'b0, "R3 event on update", {31'b0, done_evt}, 32'h0);
      end
      return;
    end
    data_busy = 1'b0;
    // R6 burst length
    chk(inits == (w[15] ? 80 : 0), "R6 init ticks", inits, w[15] ? 80 : 0);
    // R1 opcode
    chk(tx_opcode === w[5:0], "R1 opcode", {26'b0, tx_opcode}, {26'b0, w[5:0]});
    fl = {tx_rsp, tx_long, tx_crc, tx_data, tx_write, tx_autostop, tx_abort, 1'b0};
    // R5 flags
    chk(fl === exp_flags(w), "R5 flags", {24'b0, fl}, {24'b0, exp_flags(w)});
    for (int i = 0; i < int'($urandom % 4); i++) begin
      step();
      if (!tx_req || !cmd_word[31]) chk(1'b0, "R2 request dropped", {31'b0, tx_req}, 32'h1);
    end
    tx_ack = 1'b1;
    step();
    tx_ack = 1'b0;
    // R2 self clear
    chk(!cmd_word[31] && !tx_req, "R2 start cleared", {cmd_word[31], 30'b0, tx_req}, 32'h0);
    for (int i = 0; i < int'($urandom % 5); i++) step();
    tx_end = 1'b1;
    step();
    tx_end = 1'b0;
    if (!w[6]) begin
      chk(!done_evt, "R7 done early", {31'b0, done_evt}, 32'h0);
      step();
      chk(done_evt, "R7 done no response", {31'b0, done_evt}, 32'h1);
    end else if (rmode == 0) begin
      for (int i = 0; i < rdly; i++) begin
        if (timeout_evt) chk(1'b0, "R7 early timeout", 32'h1, 32'h0);
        step();
      end
      rsp_done = 1'b1;
      step();
      rsp_done = 1'b0;
      step();
      chk(done_evt && !timeout_evt, "R7 done after response",
          {30'b0, timeout_evt, done_evt}, 32'h1);
    end else begin
      guard = 0;
      while (!timeout_evt && guard < 1000) begin
        if (cclk_en) tk++;
        step();
        guard++;
      end
      // R8 timeout length
      chk(tk == exp_lim(to), "R8 timeout ticks", tk, exp_lim(to));
      step();
      chk(done_evt && !timeout_evt, "R7 done after timeout",
          {30'b0, timeout_evt, done_evt}, 32'h1);
    end
    step();
    chk(!done_evt, "R7 single pulse", {31'b0, done_evt}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int lim;
    void'($urandom(32'd4242));
    repeat (3) step();
    // R10 reset state
    chk(cmd_word === 32'h0 && clk_cfg === 2'b0, "R10 reset regs", cmd_word, 32'h0);
    chk(!tx_req && !init_hold && !done_evt && !timeout_evt, "R10 reset outputs",
        {28'b0, tx_req, init_hold, done_evt, timeout_evt}, 32'h0);
    rst_n = 1'b1;
    step();

    run_cmd(32'h8000_8000, 0, 0, 0, 16'd0, 1'b0, 32'h0);            // init burst
    run_cmd(32'h8000_0148, 0, 1, 0, 16'd0, 1'b0, 32'h0);            // default timeout
    run_cmd(32'h8000_01C2, 0, 1, 0, 16'd5, 1'b0, 32'h0);            // short timeout
    run_cmd(32'h8000_0151, 0, 0, 0, 16'd9, 1'b0, 32'h0);            // immediate response
    run_cmd(32'h8020_2000, 7, 0, 0, 16'd0, 1'b0, 32'h0);            // R3 with R4 wait
    run_cmd(32'h8000_2611, 10, 0, 3, 16'd20, 1'b0, 32'h0);          // R4 wait
    run_cmd(32'h8000_0011, 10, 0, 3, 16'd20, 1'b0, 32'h0);          // R4 no wait
    run_cmd(32'h8000_2017, 6, 0, 0, 16'd0, 1'b1, 32'h8000_003F);    // R9

    for (int n = 0; n < 60; n++) begin
      w = 32'h8000_0000 | ($urandom & 32'h0000_57FF);
      if ($urandom % 10 == 0) w[15] = 1'b1;
      if ($urandom % 4 == 0) w[13] = 1'b1;
      if ($urandom % 7 == 0) w[21] = 1'b1;
      lim = ($urandom % 2) ? 0 : 3 + int'($urandom % 25);
      run_cmd(w, int'($urandom % 8), int'($urandom % 2),
              int'($urandom % exp_lim(16'(lim))), 16'(lim), 1'b0, 32'h0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule